// File: doc/BRIEF.md
# Frame-Synchronous Descrambler with Parity Pulse Reporter

This block sits on the receive side of a byte-aligned synchronous optical transport stream, after framing has been found. Every clock it takes one byte plus a marker that flags the first byte of a frame. It leaves the framing bytes and the trace/growth bytes at the head of row one unchanged. It removes the frame-synchronous scrambling from every later byte of the frame. The restored stream leaves the block one cycle later.

Alongside the data path, the block keeps a running bit-interleaved parity (BIP-8) over every byte of a frame as received, which is still scrambled. When the next frame arrives, the block reads that frame's parity byte after descrambling. It sits in row two, column one. The block compares the parity byte with the stored result and reports the number of disagreeing bit positions as a count of pulses on one output wire. That way a simple external counter can collect the error figure. If the frame marker goes missing, the block keeps counting frame positions on its own.

The interleave factor `NUM_STS` sets the row layout. The head of row one is 3·`NUM_STS` bytes long, a row is 90·`NUM_STS` bytes, and a frame is nine rows.

Top module: `fsd_b1_monitor`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `dout`, `dout_start` and `b1_pulse` are all 0.
- R2: `dout` carries the processed byte one cycle after the byte is on `din`. `dout_start` is high exactly one cycle after `frame_start` was high, and is high at no other time.
- R3: The first 3·`NUM_STS` bytes of each frame (positions 0 to 3·`NUM_STS`−1, counted from the marked byte at position 0) appear on `dout` unchanged.
- R4: Every byte from position 3·`NUM_STS` to the end of the frame is XORed with a keystream from the generator 1 + x^6 + x^7, taken most significant bit first. The keystream's 7-bit state is set to all ones at position 3·`NUM_STS` in every frame, so the first key byte is 0xFE and the bit sequence repeats every 127 bits.
- R5: While `descr_off` is high, every byte goes to `dout` unchanged, and the parity byte is compared exactly as received.
- R6: The parity over all bytes of a frame, as received, is XORed with the descrambled byte at position 90·`NUM_STS` of the following frame. The number of 1 bits in that result, 0 to 8, equals the number of pulses on `b1_pulse`.
- R7: Each pulse is high for `PULSE_W` cycles (default 8), and consecutive pulses are separated by `PULSE_W` low cycles. The first pulse goes high on the cycle after the parity byte is on `din`.
- R8: The parity byte of the first frame after reset is not compared, and gives no pulses.
- R9: If no marker comes after 9·90·`NUM_STS` bytes of a frame, the next byte is still treated as position 0. Descrambling, parity and comparison continue as if the marker had been there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | High with the first byte of a frame |
| din | input | 8 | Received byte, still scrambled |
| descr_off | input | 1 | Bypass the descrambler when high |
| dout | output | 8 | Descrambled byte, one cycle late |
| dout_start | output | 1 | Frame marker aligned with `dout` |
| b1_pulse | output | 1 | Parity error pulse train |

## Verification
The parity byte of a frame is used twice in the same cycle. Descrambled, it is compared with the previous frame's stored parity. As received, it is folded into the parity that the current frame is building. The bench builds each frame's parity byte from its own running model of the previous frame, with a chosen error mask XORed in. That byte then becomes part of the parity checked in the next frame. The block is judged correct only when the pulse count matches the mask frame after frame, so a mistake on either side of that shared cycle shows up in the next frame's count. The same chaining holds through a frame with the bypass on and through a frame whose marker is dropped.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

    typedef logic [6:0] scr_state_t;

    localparam scr_state_t SCR_SEED = 7'h7F;

    // result of one parity comparison handed to the pulse generator
    typedef struct packed {
        logic       valid;
        logic [3:0] errs;
    } b1_report_t;

    // key byte produced from a state, most significant bit first
    function automatic logic [7:0] scr_key_byte(input scr_state_t st);
        scr_state_t s;
        logic [7:0] k;
        s = st;
        k = '0;
        for (int i = 7; i >= 0; i--) begin
            k[i] = s[6];
            s    = {s[5:0], s[6] ^ s[5]};
        end
        return k;
    endfunction

    // state after eight bit steps
    function automatic scr_state_t scr_advance8(input scr_state_t st);
        scr_state_t s;
        s = st;
        for (int i = 0; i < 8; i++) begin
            s = {s[5:0], s[6] ^ s[5]};
        end
        return s;
    endfunction

    function automatic logic [3:0] ones8(input logic [7:0] b);
        logic [3:0] n;
        n = '0;
        for (int i = 0; i < 8; i++) begin
            n = n + {3'b000, b[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/fsd_frame_pos.sv
module fsd_frame_pos #(
    parameter int FRAME_LEN = 2430,
    localparam int PW = $clog2(FRAME_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_start,
    output logic [PW-1:0] pos,
    output logic          boundary,
    output logic          in_frame,
    output logic          was_framed
);
    logic [PW-1:0] pos_q;
    logic          seen_q;

    // a frame begins on a marker, or when a framed count runs off the end
    assign boundary   = frame_start | (seen_q && pos_q == PW'(FRAME_LEN - 1));
    assign in_frame   = frame_start | seen_q;
    assign was_framed = seen_q;

    always_comb begin
        if (boundary)
            pos = '0;
        else if (seen_q)
            pos = pos_q + 1'b1;
        else
            pos = pos_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            pos_q  <= pos;
            seen_q <= in_frame;
        end
    end
endmodule

// File: rtl/fsd_scrambler.sv
module fsd_scrambler
    import fsd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reseed,
    output logic [7:0] key
);
    scr_state_t st_q;

    assign key = scr_key_byte(st_q);

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= SCR_SEED;
        else if (reseed)
            st_q <= SCR_SEED;
        else
            st_q <= scr_advance8(st_q);
    end
endmodule

// File: rtl/fsd_b1_check.sv
module fsd_b1_check
    import fsd_pkg::*;
#(
    parameter int FRAME_LEN = 2430,
    parameter int B1_POS    = 270,
    localparam int PW = $clog2(FRAME_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          boundary,
    input  logic          in_frame,
    input  logic          was_framed,
    input  logic [PW-1:0] pos,
    input  logic [7:0]    raw_byte,
    input  logic [7:0]    clean_byte,
    output b1_report_t    report
);
    logic [7:0] bip_acc_q;
    logic [7:0] bip_prev_q;
    logic       prev_ok_q;

    always_comb begin
        report.valid = in_frame && prev_ok_q && (pos == PW'(B1_POS));
        report.errs  = ones8(clean_byte ^ bip_prev_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bip_acc_q  <= '0;
            bip_prev_q <= '0;
            prev_ok_q  <= 1'b0;
        end else if (boundary) begin
            bip_prev_q <= bip_acc_q;
            prev_ok_q  <= was_framed;
            bip_acc_q  <= raw_byte;
        end else if (in_frame) begin
            bip_acc_q  <= bip_acc_q ^ raw_byte;
        end
    end
endmodule

// File: rtl/fsd_pulse_train.sv
module fsd_pulse_train
    import fsd_pkg::*;
#(
    parameter int PULSE_W = 8,
    localparam int TW = $clog2(2 * PULSE_W)
) (
    input  logic       clk,
    input  logic       rst,
    input  b1_report_t report,
    output logic       pulse
);
    logic [3:0]    left_q;
    logic [TW-1:0] tick_q;

    assign pulse = (left_q != '0) && (tick_q < TW'(PULSE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            tick_q <= '0;
        end else if (report.valid) begin
            left_q <= report.errs;
            tick_q <= '0;
        end else if (left_q != '0) begin
            if (tick_q == TW'(2 * PULSE_W - 1)) begin
                tick_q <= '0;
                left_q <= left_q - 1'b1;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fsd_b1_monitor.sv
module fsd_b1_monitor
    import fsd_pkg::*;
#(
    parameter int NUM_STS      = 3,
    parameter int COLS_PER_STS = 90,
    parameter int ROWS         = 9,
    parameter int PULSE_W      = 8,
    localparam int HDR_LEN   = 3 * NUM_STS,
    localparam int ROW_LEN   = COLS_PER_STS * NUM_STS,
    localparam int FRAME_LEN = ROWS * ROW_LEN,
    localparam int PW        = $clog2(FRAME_LEN)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_start,
    input  logic [7:0] din,
    input  logic       descr_off,
    output logic [7:0] dout,
    output logic       dout_start,
    output logic       b1_pulse
);
    logic [PW-1:0] pos;
    logic          boundary;
    logic          in_frame;
    logic          was_framed;
    logic [7:0]    key;
    logic          reseed;
    logic          scr_en;
    logic [7:0]    clean;
    b1_report_t    report;

    fsd_frame_pos #(.FRAME_LEN(FRAME_LEN)) u_pos (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .pos        (pos),
        .boundary   (boundary),
        .in_frame   (in_frame),
        .was_framed (was_framed)
    );

    // state is loaded with the last head byte so the next byte sees the seed
    assign reseed = in_frame && (pos == PW'(HDR_LEN - 1));

    fsd_scrambler u_scr (
        .clk   (clk),
        .rst   (rst),
        .reseed(reseed),
        .key   (key)
    );

    assign scr_en = in_frame && !descr_off && (pos >= PW'(HDR_LEN));
    assign clean  = scr_en ? (din ^ key) : din;

    fsd_b1_check #(.FRAME_LEN(FRAME_LEN), .B1_POS(ROW_LEN)) u_chk (
        .clk       (clk),
        .rst       (rst),
        .boundary  (boundary),
        .in_frame  (in_frame),
        .was_framed(was_framed),
        .pos       (pos),
        .raw_byte  (din),
        .clean_byte(clean),
        .report    (report)
    );

    fsd_pulse_train #(.PULSE_W(PULSE_W)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .report(report),
        .pulse (b1_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout       <= '0;
            dout_start <= 1'b0;
        end else begin
            dout       <= clean;
            dout_start <= frame_start;
        end
    end
endmodule

// File: rtl/fsd_b1_monitor_chk.sv
module fsd_b1_monitor_chk #(
    parameter int PULSE_W = 8,
    localparam int HW = $clog2(PULSE_W) + 2
) (
    input logic       clk,
    input logic       rst,
    input logic       frame_start,
    input logic [7:0] din,
    input logic       descr_off,
    input logic [7:0] dout,
    input logic       dout_start,
    input logic       b1_pulse
);
    logic [HW-1:0] hi_run;
    logic          marker_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run      <= '0;
            marker_seen <= 1'b0;
        end else begin
            hi_run      <= b1_pulse ? hi_run + 1'b1 : '0;
            marker_seen <= marker_seen | frame_start;
        end
    end

    // R7
    pulse_high_len_chk: assert property (@(posedge clk) disable iff (rst)
        b1_pulse |-> hi_run < HW'(PULSE_W));

    // R7
    pulse_end_len_chk: assert property (@(posedge clk) disable iff (rst)
        (!b1_pulse && hi_run != '0) |-> hi_run == HW'(PULSE_W));

    // R8
    no_unframed_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        b1_pulse |-> marker_seen);

    // R2
    start_delay_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> dout_start == $past(frame_start));

    // R3
    head_pass_chk: assert property (@(posedge clk) disable iff (rst)
        dout_start |-> dout == $past(din));

    // R5
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(descr_off)) |-> dout == $past(din));
endmodule

bind fsd_b1_monitor fsd_b1_monitor_chk #(.PULSE_W(PULSE_W)) i_fsd_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .din        (din),
    .descr_off  (descr_off),
    .dout       (dout),
    .dout_start (dout_start),
    .b1_pulse   (b1_pulse)
);

// File: tb/test_fsd_b1_monitor.sv
module test_fsd_b1_monitor;
    localparam int N      = 3;
    localparam int HDR    = 3 * N;
    localparam int ROWL   = 90 * N;
    localparam int FLEN   = 9 * ROWL;
    localparam int PW_EXP = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_start = 1'b0;
    logic [7:0] din = '0;
    logic       descr_off = 1'b0;
    logic [7:0] dout;
    logic       dout_start;
    logic       b1_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fsd_b1_monitor i_fsd_b1_monitor (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .din        (din),
        .descr_off  (descr_off),
        .dout       (dout),
        .dout_start (dout_start),
        .b1_pulse   (b1_pulse)
    );

    // cycle counter and pulse monitor
    int pcyc = 0;
    always @(posedge clk) pcyc <= pcyc + 1;

    int mon_rises = 0, mon_first = -1, mon_bad = 0, hi_len = 0, lo_len = 0;
    bit mon_last = 1'b0;
    always @(negedge clk) begin
        if (b1_pulse) begin
            if (!mon_last) begin
                mon_rises++;
                if (mon_rises == 1) mon_first = pcyc;
                else if (lo_len != PW_EXP) mon_bad++;
                hi_len = 1;
            end else hi_len++;
        end else begin
            if (mon_last) begin
                if (hi_len != PW_EXP) mon_bad++;
                lo_len = 1;
            end else lo_len++;
        end
        mon_last = b1_pulse;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp,
                       input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // bench model state
    logic [6:0] ks;
    logic [7:0] acc = '0, prev_bip = '0;
    bit         has_prev = 1'b0;
    logic [7:0] exp_prev = '0;
    bit         exp_st_prev = 1'b0, exp_valid = 1'b0, prev_key0 = 1'b0;
    bit         prev_hdr = 1'b0;
    int         fseed = 0;

    function automatic logic [7:0] next_key(inout logic [6:0] s);
        logic [7:0] k;
        for (int b = 7; b >= 0; b--) begin
            k[b] = s[6];
            s = {s[5:0], s[6] ^ s[5]};
        end
        return k;
    endfunction

    function automatic int pop8(input logic [7:0] v);
        int n = 0;
        for (int b = 0; b < 8; b++) n += v[b];
        return n;
    endfunction

    task automatic send_frame(input logic [7:0] mask, input bit mark, input bit off,
                              input string req);
        int hdr_bad = 0, body_bad = 0, st_bad = 0, fe_bad = 0, b1_cyc = 0, exp_cnt;
        logic [7:0] b, k, e;
        exp_cnt = has_prev ? pop8(mask) : 0;
        fseed++;
        for (int p = 0; p < FLEN; p++) begin
            @(posedge clk); #1;
            if (p == HDR) ks = 7'h7F;
            k = 8'h00;
            if (p >= HDR) k = next_key(ks);
            if (p < N) b = 8'hF6;
            else if (p < 2 * N) b = 8'h28;
            else if (p < HDR) b = 8'(p - 2 * N + 1);
            else if (p == HDR) b = 8'h00;
            else if (p == ROWL && has_prev) b = off ? (prev_bip ^ mask) : (prev_bip ^ mask ^ k);
            else b = 8'(p * 13 + fseed * 7 + (p >> 3));
            if (p == ROWL) b1_cyc = pcyc;
            if (p == 0) begin mon_rises = 0; mon_first = -1; mon_bad = 0; end
            frame_start = mark && (p == 0);
            descr_off   = off;
            din         = b;
            acc         = (p == 0) ? b : (acc ^ b);
            e = (p < HDR || off) ? b : (b ^ k);
            @(negedge clk);
            if (exp_valid) begin
                if (dout != exp_prev) begin
                    if (prev_hdr) hdr_bad++; else body_bad++;
                end
                if (dout_start != exp_st_prev) st_bad++;
                if (prev_key0 && dout != 8'hFE) fe_bad++;
            end
            exp_prev    = e;
            exp_st_prev = frame_start;
            exp_valid   = 1'b1;
            prev_hdr    = (p < HDR);
            prev_key0   = (p == HDR) && !off;
        end
        prev_bip = acc;
        has_prev = 1'b1;
        chk(hdr_bad == 0, "R3", hdr_bad, 0, {req, " head bytes changed"});
        chk(body_bad == 0, off ? "R5" : "R4", body_bad, 0, {req, " body byte mismatches"});
        chk(fe_bad == 0, "R4", fe_bad, 0, {req, " first key byte not 0xFE"});
        chk(st_bad == 0, "R2", st_bad, 0, {req, " marker alignment errors"});
        chk(mon_rises == exp_cnt, req, mon_rises, exp_cnt, "pulse count");
        chk(mon_bad == 0, "R7", mon_bad, 0, {req, " pulse or gap length errors"});
        if (exp_cnt > 0)
            chk(mon_first == b1_cyc + 1, "R7", mon_first, b1_cyc + 1, {req, " first pulse cycle"});
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(dout == 0 && !dout_start && !b1_pulse, "R1", {dout, dout_start, b1_pulse}, 0,
            "outputs during reset");
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk(dout == 0 && !dout_start && !b1_pulse, "R1", {dout, dout_start, b1_pulse}, 0,
            "outputs after reset");
    endtask

    task automatic t_first_frame; send_frame(8'h5A, 1'b1, 1'b0, "R8"); endtask
    task automatic t_clean;       send_frame(8'h00, 1'b1, 1'b0, "R6"); endtask
    task automatic t_single;      send_frame(8'h10, 1'b1, 1'b0, "R6"); endtask
    task automatic t_full;        send_frame(8'hFF, 1'b1, 1'b0, "R6"); endtask
    task automatic t_mixed;       send_frame(8'hA5, 1'b1, 1'b0, "R6"); endtask
    task automatic t_bypass;      send_frame(8'h03, 1'b1, 1'b1, "R5"); endtask
    task automatic t_flywheel;    send_frame(8'h81, 1'b0, 1'b0, "R9"); endtask
    task automatic t_resume;      send_frame(8'h0F, 1'b1, 1'b0, "R9"); endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_first_frame();
        t_clean();
        t_single();
        t_full();
        t_mixed();
        t_bypass();
        t_flywheel();
        t_resume();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule